// File: doc/BRIEF.md
# Child Task Launch and Completion Controller

This block sits between a parent scheduler and one child task in a hierarchical dataflow accelerator. It turns a global start pulse into a start request toward the child. It waits for the child to accept that request and to complete, then raises a completion flag toward the parent. The flag stays up until the parent's global done indication returns.

Every control signal that crosses between parent and child goes through a register chain whose length is a parameter, so the controller can be placed far from the parent on a large die. The active-low reset, the global start, the global done and the completion flag each pass through such a chain. A zero-length chain is a plain wire.

A second variant, chosen by parameter, serves children that run forever. It has no handshake. The start request is raised once the delayed global start is seen and stays up until reset.

Top module: `child_hs_ctrl`

## Requirements
- R1: Reset, global start and global done each reach the controller through exactly STAGES registers; with STAGES=0 they reach it directly.
- R2: From idle, only a high delayed global start moves the controller on, to the starting state; child ready, child done and global done seen while idle change no output.
- R3: `kid_start` is high exactly while the controller is in the starting state, and it stays high for as long as child ready stays low. It rises STAGES+1 cycles after the raw global start.
- R4: In starting, child ready and child done high in the same cycle lead directly to the finished state. `kid_start` falls one cycle later.
- R5: In starting, child ready with child done low leads to the running state. `kid_start` falls, and the controller stays there with no completion flag until child done goes high.
- R6: The finished state is held until the delayed global done is high, and then the controller returns to idle. Global done has no effect while running.
- R7: `kid_finished` is the condition "state is finished" delayed through STAGES registers: it rises STAGES+1 cycles after the child done that completes the handshake and falls 2*STAGES+1 cycles after the raw global done.
- R8: While the delayed reset is low the state is idle, so `kid_start` is low STAGES+1 cycles after `rst_n` falls.
- R9: With AUTORUN=1, `kid_start` rises STAGES+1 cycles after the raw global start and then stays high whatever ready, done or global done do. `kid_finished` stays low.
- R10: With AUTORUN=1, `kid_start` is cleared one cycle after the delayed reset goes low, which is STAGES+1 cycles after `rst_n` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, delayed internally |
| glb_start | input | 1 | Global start pulse from the parent |
| glb_done | input | 1 | Global done indication from the parent |
| kid_ready | input | 1 | Child accepted the start request |
| kid_done | input | 1 | Child completed its run |
| kid_start | output | 1 | Start request toward the child |
| kid_finished | output | 1 | Delayed completion flag toward the parent |

## Verification
The hardest case to reach is the one where child ready and child done arrive in the same cycle. This must skip the running state, and the result shows only as a delayed completion flag. The bench drives three instances with chain lengths 0, 1 and 3 from the same stimulus. It waits until all three sit in the starting state, then asserts ready and done together for a single cycle. It time-stamps every output edge, so each latency is compared with the value the chain length predicts. The separate ready-then-done path is driven the same way, with a global done pulse placed while running to show that it is ignored.

// File: rtl/chs_pkg.sv
package chs_pkg;
   // handshake state encoding
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ARM  = 2'b01,
      ST_BUSY = 2'b11,
      ST_FIN  = 2'b10
   } hs_state_e;

   localparam int unsigned MAX_STAGES = 32;
endpackage

// File: rtl/chs_delay.sv
module chs_delay #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 1
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_wire
         assign q = d;
      end else begin : g_regs
         logic [STAGES-1:0][W-1:0] pipe;
         always_ff @(posedge clk) pipe[0] <= d;
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) pipe[i] <= pipe[i-1];
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/chs_fsm.sv
module chs_fsm
   import chs_pkg::*;
(
   input  logic clk,
   input  logic rst_dly,
   input  logic start_dly,
   input  logic done_dly,
   input  logic kid_ready,
   input  logic kid_done,
   output logic kid_start,
   output logic at_fin
);
   hs_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start_dly) st_d = ST_ARM;
         ST_ARM:  if (kid_ready) st_d = kid_done ? ST_FIN : ST_BUSY;
         ST_BUSY: if (kid_done)  st_d = ST_FIN;
         ST_FIN:  if (done_dly)  st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_dly) st_q <= ST_IDLE;
      else          st_q <= st_d;
   end

   assign kid_start = (st_q == ST_ARM);
   assign at_fin    = (st_q == ST_FIN);
endmodule

// File: rtl/chs_autorun.sv
module chs_autorun (
   input  logic clk,
   input  logic rst_dly,
   input  logic start_dly,
   output logic kid_start
);
   logic run_q;

   always_ff @(posedge clk) begin
      if (!rst_dly)       run_q <= 1'b0;
      else if (start_dly) run_q <= 1'b1;
   end

   assign kid_start = run_q;
endmodule

// File: rtl/child_hs_ctrl.sv
module child_hs_ctrl
   import chs_pkg::*;
#(
   parameter int unsigned STAGES  = 2,
   parameter bit          AUTORUN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic glb_start,
   input  logic glb_done,
   input  logic kid_ready,
   input  logic kid_done,
   output logic kid_start,
   output logic kid_finished
);
   localparam int unsigned CTL_W = 3;

   generate
      if (STAGES > MAX_STAGES) begin : g_bad_stages
         $error("child_hs_ctrl: STAGES exceeds MAX_STAGES");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_raw, ctl_dly;
   logic rst_dly, start_dly, done_dly;

   assign ctl_raw = {rst_n, glb_start, glb_done};

   chs_delay #(.W(CTL_W), .STAGES(STAGES)) u_ctl_dly (
      .clk (clk),
      .d   (ctl_raw),
      .q   (ctl_dly)
   );

   assign rst_dly   = ctl_dly[2];
   assign start_dly = ctl_dly[1];
   assign done_dly  = ctl_dly[0];

   generate
      if (AUTORUN) begin : g_auto
         chs_autorun u_auto (
            .clk       (clk),
            .rst_dly   (rst_dly),
            .start_dly (start_dly),
            .kid_start (kid_start)
         );
         assign kid_finished = 1'b0;
      end else begin : g_hs
         logic at_fin;
         chs_fsm u_fsm (
            .clk       (clk),
            .rst_dly   (rst_dly),
            .start_dly (start_dly),
            .done_dly  (done_dly),
            .kid_ready (kid_ready),
            .kid_done  (kid_done),
            .kid_start (kid_start),
            .at_fin    (at_fin)
         );
         chs_delay #(.W(1), .STAGES(STAGES)) u_fin_dly (
            .clk (clk),
            .d   (at_fin),
            .q   (kid_finished)
         );
      end
   endgenerate
endmodule

// File: rtl/chs_chk.sv
module chs_chk #(
   parameter bit AUTORUN = 1'b0
) (
   input logic clk,
   input logic rst_dly,
   input logic start_dly,
   input logic kid_ready,
   input logic kid_start,
   input logic kid_finished
);
   // R8 R10
   reset_idle_chk: assert property (@(posedge clk) !rst_dly |=> !kid_start);

   generate
      if (AUTORUN) begin : g_auto
         // R9
         start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_dly)
            kid_start |=> kid_start);
         // R9
         no_finish_chk: assert property (@(posedge clk) disable iff (!rst_dly)
            !kid_finished);
      end else begin : g_hs
         // R3
         start_hold_chk: assert property (@(posedge clk) disable iff (!rst_dly)
            kid_start && !kid_ready |=> kid_start);
         // R4
         start_drop_chk: assert property (@(posedge clk) disable iff (!rst_dly)
            kid_start && kid_ready |=> !kid_start);
         // R2
         no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_dly)
            !kid_start && !start_dly |=> !kid_start);
      end
   endgenerate
endmodule

bind child_hs_ctrl chs_chk #(.AUTORUN(AUTORUN)) u_chk (
   .clk          (clk),
   .rst_dly      (rst_dly),
   .start_dly    (start_dly),
   .kid_ready    (kid_ready),
   .kid_start    (kid_start),
   .kid_finished (kid_finished)
);

// File: tb/tb_child_hs_ctrl.sv
`timescale 1ns/1ps
module tb_child_hs_ctrl;
   localparam int NFSM = 3;
   localparam int LV [NFSM] = '{0, 1, 3};
   localparam int AR_L = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0, glb_start = 1'b0, glb_done = 1'b0;
   logic kid_ready = 1'b0, kid_done = 1'b0;
   logic [3:0] ks, kf, pks, pkf;
   int cyc = 0;
   int nchk = 0, nfail = 0;
   bit over = 1'b0;
   int st_rise [4], st_fall [4], fn_rise [4], fn_fall [4];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   child_hs_ctrl #(.STAGES(0), .AUTORUN(1'b0)) dut_l0 (.clk(clk), .rst_n(rst_n),
      .glb_start(glb_start), .glb_done(glb_done), .kid_ready(kid_ready),
      .kid_done(kid_done), .kid_start(ks[0]), .kid_finished(kf[0]));
   child_hs_ctrl #(.STAGES(1), .AUTORUN(1'b0)) dut_l1 (.clk(clk), .rst_n(rst_n),
      .glb_start(glb_start), .glb_done(glb_done), .kid_ready(kid_ready),
      .kid_done(kid_done), .kid_start(ks[1]), .kid_finished(kf[1]));
   child_hs_ctrl #(.STAGES(3), .AUTORUN(1'b0)) dut (.clk(clk), .rst_n(rst_n),
      .glb_start(glb_start), .glb_done(glb_done), .kid_ready(kid_ready),
      .kid_done(kid_done), .kid_start(ks[2]), .kid_finished(kf[2]));
   child_hs_ctrl #(.STAGES(AR_L), .AUTORUN(1'b1)) dut_ar (.clk(clk), .rst_n(rst_n),
      .glb_start(glb_start), .glb_done(glb_done), .kid_ready(kid_ready),
      .kid_done(kid_done), .kid_start(ks[3]), .kid_finished(kf[3]));

   // edge time-stamps, taken away from the active edge
   initial begin
      pks = '0; pkf = '0;
      for (int i = 0; i < 4; i++) begin
         st_rise[i] = -1; st_fall[i] = -1; fn_rise[i] = -1; fn_fall[i] = -1;
      end
   end
   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) begin
         if (ks[i] && !pks[i]) st_rise[i] = cyc;
         if (!ks[i] && pks[i]) st_fall[i] = cyc;
         if (kf[i] && !pkf[i]) fn_rise[i] = cyc;
         if (!kf[i] && pkf[i]) fn_fall[i] = cyc;
      end
      pks = ks; pkf = kf;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_start(output int s);
      @(negedge clk); s = cyc; glb_start = 1'b1;
      @(negedge clk); glb_start = 1'b0;
   endtask

   task automatic pulse_gdone(output int s);
      @(negedge clk); s = cyc; glb_done = 1'b1;
      @(negedge clk); glb_done = 1'b0;
   endtask

   task automatic t_reset_state;
      idle_cycles(1);
      for (int i = 0; i < 4; i++) begin
         check(ks[i] == 1'b0, "R8 start low in reset", ks[i], 0);
         check(kf[i] == 1'b0, "R8 finished low in reset", kf[i], 0);
      end
   endtask

   task automatic t_idle_ignore;
      @(negedge clk); kid_ready = 1'b1; kid_done = 1'b1; glb_done = 1'b1;
      @(negedge clk); kid_ready = 1'b0; kid_done = 1'b0; glb_done = 1'b0;
      idle_cycles(8);
      for (int i = 0; i < NFSM; i++) begin
         check(ks[i] == 1'b0, "R2 idle ignores ready/done", ks[i], 0);
         check(kf[i] == 1'b0, "R2 idle no finish", kf[i], 0);
      end
      check(ks[3] == 1'b0, "R9 autorun waits for start", ks[3], 0);
   endtask

   task automatic t_start_latency;
      int s;
      pulse_start(s);
      idle_cycles(6);
      for (int i = 0; i < NFSM; i++) begin
         check(st_rise[i] == s + LV[i] + 1, "R1 R3 start latency", st_rise[i], s + LV[i] + 1);
         check(ks[i] == 1'b1, "R3 start held without ready", ks[i], 1);
      end
      check(st_rise[3] == s + AR_L + 1, "R9 autorun start latency", st_rise[3], s + AR_L + 1);
   endtask

   task automatic t_same_cycle;
      int s;
      @(negedge clk); s = cyc; kid_ready = 1'b1; kid_done = 1'b1;
      @(negedge clk); kid_ready = 1'b0; kid_done = 1'b0;
      idle_cycles(7);
      for (int i = 0; i < NFSM; i++) begin
         check(st_fall[i] == s + 1, "R4 start drops", st_fall[i], s + 1);
         check(fn_rise[i] == s + LV[i] + 1, "R4 R7 finished latency", fn_rise[i], s + LV[i] + 1);
      end
      check(ks[3] == 1'b1, "R9 autorun ignores ready/done", ks[3], 1);
   endtask

   task automatic t_gdone_release;
      int g;
      idle_cycles(4);
      for (int i = 0; i < NFSM; i++)
         check(kf[i] == 1'b1, "R6 finished held", kf[i], 1);
      pulse_gdone(g);
      idle_cycles(10);
      for (int i = 0; i < NFSM; i++) begin
         check(fn_fall[i] == g + 2 * LV[i] + 1, "R6 R7 release latency", fn_fall[i], g + 2 * LV[i] + 1);
         check(ks[i] == 1'b0, "R6 back to idle", ks[i], 0);
      end
      check(ks[3] == 1'b1, "R9 autorun ignores global done", ks[3], 1);
      check(kf[3] == 1'b0, "R9 autorun never finishes", kf[3], 0);
   endtask

   task automatic t_separate;
      int s, r, g, d;
      pulse_start(s);
      idle_cycles(6);
      @(negedge clk); r = cyc; kid_ready = 1'b1;
      @(negedge clk); kid_ready = 1'b0;
      idle_cycles(3);
      for (int i = 0; i < NFSM; i++) begin
         check(st_fall[i] == r + 1, "R5 start drops on ready", st_fall[i], r + 1);
         check(kf[i] == 1'b0, "R5 running not finished", kf[i], 0);
      end
      pulse_gdone(g);
      idle_cycles(8);
      for (int i = 0; i < NFSM; i++) begin
         check(kf[i] == 1'b0, "R6 global done ignored while running", kf[i], 0);
         check(ks[i] == 1'b0, "R5 running keeps start low", ks[i], 0);
      end
      @(negedge clk); d = cyc; kid_done = 1'b1;
      @(negedge clk); kid_done = 1'b0;
      idle_cycles(6);
      for (int i = 0; i < NFSM; i++)
         check(fn_rise[i] == d + LV[i] + 1, "R5 R7 finish after done", fn_rise[i], d + LV[i] + 1);
      pulse_gdone(g);
      idle_cycles(10);
      for (int i = 0; i < NFSM; i++)
         check(kf[i] == 1'b0, "R6 released", kf[i], 0);
   endtask

   task automatic t_reset_mid;
      int s, t;
      pulse_start(s);
      idle_cycles(6);
      @(negedge clk); t = cyc; rst_n = 1'b0;
      idle_cycles(7);
      for (int i = 0; i < NFSM; i++)
         check(st_fall[i] == t + LV[i] + 1, "R8 reset forces idle", st_fall[i], t + LV[i] + 1);
      check(st_fall[3] == t + AR_L + 1, "R10 autorun cleared by reset", st_fall[3], t + AR_L + 1);
      @(negedge clk); rst_n = 1'b1;
      idle_cycles(6);
      for (int i = 0; i < 4; i++)
         check(ks[i] == 1'b0, "R8 R10 stays idle after reset", ks[i], 0);
   endtask

   initial begin
      idle_cycles(8);
      t_reset_state();
      @(negedge clk); rst_n = 1'b1;
      idle_cycles(6);
      t_idle_ignore();
      t_start_latency();
      t_same_cycle();
      t_gdone_release();
      t_separate();
      t_reset_mid();
      if (!over) begin
         over = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #(5.0 * 100000);
      if (!over) begin
         over = 1'b1;
         nchk++; nfail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule